// File: doc/BRIEF.md
# Data-Processing ALU with NZCV Condition Flags

This block is the integer execute unit of a 32-bit RISC pipeline. It takes a first operand, a second operand that an upstream shifter or immediate rotator has already formed, the carry bit that the shifter produced, and a flag that says whether a shift or rotation took place. It also takes a 4-bit operation code, a set-flags bit and the current NZCV flags. From these it computes one of sixteen logical, arithmetic, reverse-subtract, carry-chained or compare/test operations.

The result, a destination-write enable and the next NZCV flags are registered. They appear one clock after an input beat that is marked valid. Register file access, the shifter itself and conditional execution belong to neighbouring blocks. The write enable tells the register file whether the result should be retired. The flag outputs feed the status register.

Top module: `dp_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `out_valid`=0, `wr_en`=0, `result`=0 and `flags_out`=0.
- R2: An input beat with `in_valid`=1 produces exactly one output beat with `out_valid`=1 on the following rising edge. A cycle with `in_valid`=0 produces `out_valid`=0 and `wr_en`=0.
- R3: The logical codes give these results: 0x0 is a AND b, 0x1 is a XOR b, 0xC is a OR b, 0xD is b, 0xE is a AND NOT b, and 0xF is NOT b, where the first operand is ignored.
- R4: The arithmetic codes give these results modulo 2^32: 0x2 is a-b, 0x3 is b-a, 0x4 is a+b, 0x5 is a+b+C, 0x6 is a-b-(1-C), and 0x7 is b-a-(1-C). C is `flags_in[1]`.
- R5: The test and compare codes 0x8 (AND), 0x9 (XOR), 0xA (a-b) and 0xB (a+b) never assert `wr_en`. They always update the flags, whatever `set_flags` is. `result` carries the value they computed.
- R6: When flags update, N (`flags_out[3]`) is result bit 31 and Z (`flags_out[2]`) is 1 exactly when the result is zero. The flag bus order is N=bit 3, Z=bit 2, C=bit 1, V=bit 0.
- R7: For arithmetic codes with a flag update, C is the unsigned carry out of the addition, and for subtracting forms it is the inverse of the borrow. V is set when the two's-complement result is outside the signed 32-bit range.
- R8: For logical and test codes with a flag update, C takes `shf_carry` when `shf_active`=1 and otherwise keeps `flags_in[1]`. V always keeps `flags_in[0]`.
- R9: For codes other than 0x8 to 0xB with `set_flags`=0, `flags_out` equals `flags_in`.
- R10: Every valid beat with a code outside 0x8 to 0xB asserts `wr_en` in its output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat qualifier |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand after shift or rotate |
| shf_carry | input | 1 | Carry produced by the shifter |
| shf_active | input | 1 | A shift or rotation occurred |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Request a flag update |
| flags_in | input | 4 | Current NZCV flags |
| out_valid | output | 1 | Output beat qualifier |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Destination write enable |
| flags_out | output | 4 | Next NZCV flags |

## Verification
Every output of this block is due exactly one rising edge after the edge that captured its input beat. The bench drives a beat on a falling edge and pushes the expected result, write enable and flags into a queue at that moment. A monitor wakes on each falling edge, so it samples half a cycle after the capturing edge. When it sees `out_valid`, it pops the oldest entry and compares against it. Idle gaps are placed between beats, and any output beat without a pending entry, or any entry left at the end, is reported against R2.

// File: rtl/dp_alu_pkg.sv
`timescale 1ns/1ps
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_XOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_OR  = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Codes 8..B only set flags
  function automatic logic op_is_compare(alu_op_e op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
                       OP_CMP, OP_CMN});
  endfunction

endpackage

// File: rtl/dp_alu_logic.sv
`timescale 1ns/1ps
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  // One bitwise cell per lane; the op decode is shared
  for (genvar i = 0; i < W; i++) begin : g_lane
    always_comb begin
      unique case (op)
        OP_AND, OP_TST: y[i] = a[i] & b[i];
        OP_XOR, OP_TEQ: y[i] = a[i] ^ b[i];
        OP_OR:          y[i] = a[i] | b[i];
        OP_MOV:         y[i] = b[i];
        OP_BIC:         y[i] = a[i] & ~b[i];
        OP_MVN:         y[i] = ~b[i];
        default:        y[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/dp_alu_arith.sv
`timescale 1ns/1ps
module dp_alu_arith
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         v_out
);

  localparam int MSB = W - 1;

  logic [W-1:0] x, y;
  logic         ci;
  logic [W:0]   wide;

  // Every form reduces to x + y + ci on one adder
  always_comb begin
    x  = a;
    y  = b;
    ci = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: begin y = ~b; ci = 1'b1; end
      OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
      OP_ADD, OP_CMN: begin ci = 1'b0; end
      OP_ADC:         begin ci = c_in; end
      OP_SBC:         begin y = ~b; ci = c_in; end
      OP_RSC:         begin x = b; y = ~a; ci = c_in; end
      default:        begin ci = 1'b0; end
    endcase
  end

  assign wide  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign sum   = wide[MSB:0];
  assign c_out = wide[W];
  assign v_out = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);

endmodule

// File: rtl/dp_alu_flags.sv
`timescale 1ns/1ps
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  alu_op_e      op,
  input  logic         add_c,
  input  logic         add_v,
  input  logic         shf_carry,
  input  logic         shf_active,
  input  logic         set_flags,
  input  nzcv_t        cur,
  output nzcv_t        nxt,
  output logic         dest_we
);

  logic  upd;
  nzcv_t calc;

  always_comb begin
    calc.n = res[W-1];
    calc.z = (res == '0);
    if (op_is_arith(op)) begin
      calc.c = add_c;
      calc.v = add_v;
    end else begin
      calc.c = shf_active ? shf_carry : cur.c;
      calc.v = cur.v;
    end
  end

  assign upd     = set_flags | op_is_compare(op);
  assign nxt     = upd ? calc : cur;
  assign dest_we = ~op_is_compare(op);

endmodule

// File: rtl/dp_alu.sv
`timescale 1ns/1ps
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         shf_carry,
  input  logic         shf_active,
  input  logic [3:0]   opcode,
  input  logic         set_flags,
  input  logic [3:0]   flags_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   flags_out
);

  alu_op_e      op;
  nzcv_t        cur, nxt;
  logic [W-1:0] lg_y, ar_sum, res_c;
  logic         ar_c, ar_v, dest_we;

  assign op  = alu_op_e'(opcode);
  assign cur = nzcv_t'(flags_in);

  dp_alu_logic #(.W(W)) u_logic (
    .a(opnd_a), .b(opnd_b), .op(op), .y(lg_y)
  );

  dp_alu_arith #(.W(W)) u_arith (
    .a(opnd_a), .b(opnd_b), .op(op), .c_in(cur.c),
    .sum(ar_sum), .c_out(ar_c), .v_out(ar_v)
  );

  assign res_c = op_is_arith(op) ? ar_sum : lg_y;

  dp_alu_flags #(.W(W)) u_flags (
    .res(res_c), .op(op), .add_c(ar_c), .add_v(ar_v),
    .shf_carry(shf_carry), .shf_active(shf_active),
    .set_flags(set_flags), .cur(cur), .nxt(nxt), .dest_we(dest_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else if (in_valid) begin
      out_valid <= 1'b1;
      wr_en     <= dest_we;
      result    <= res_c;
      flags_out <= nxt;
    end else begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
    end
  end

endmodule

// File: rtl/dp_alu_chk.sv
`timescale 1ns/1ps
module dp_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         shf_carry,
  input logic         shf_active,
  input logic [3:0]   opcode,
  input logic         set_flags,
  input logic [3:0]   flags_in,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic [3:0]   flags_out
);

  logic is_cmp, is_logic;
  assign is_cmp   = (opcode[3:2] == 2'b10);
  assign is_logic = (opcode == 4'h0) || (opcode == 4'h1) || (opcode == 4'h8) ||
                    (opcode == 4'h9) || (opcode[3:2] == 2'b11);

  assert_beat_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_en));

  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_cmp) |=> !wr_en);

  assert_write_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_cmp) |=> wr_en);

  assert_nz_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (set_flags || is_cmp)) |=>
      (flags_out[3] == result[W-1]) && (flags_out[2] == (result == '0)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !set_flags && !is_cmp) |=> (flags_out == $past(flags_in)));

  assert_logic_v_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_logic) |=> (flags_out[0] == $past(flags_in[0])));

  assert_mvn_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 4'hF) |=> (result == ~$past(opnd_b)));

endmodule

bind dp_alu dp_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a),
  .opnd_b(opnd_b), .shf_carry(shf_carry), .shf_active(shf_active),
  .opcode(opcode), .set_flags(set_flags), .flags_in(flags_in),
  .out_valid(out_valid), .result(result), .wr_en(wr_en),
  .flags_out(flags_out)
);

// File: tb/sim_dp_alu.sv
`timescale 1ns/1ps
module sim_dp_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        shf_carry = 1'b0, shf_active = 1'b0;
  logic [3:0]  opcode = '0;
  logic        set_flags = 1'b0;
  logic [3:0]  flags_in = '0;
  logic        out_valid, wr_en;
  logic [31:0] result;
  logic [3:0]  flags_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic [3:0]  fl;
    logic [3:0]  op;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  dp_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .shf_carry(shf_carry), .shf_active(shf_active),
    .opcode(opcode), .set_flags(set_flags), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .wr_en(wr_en),
    .flags_out(flags_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic bit out_of_range(longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  function automatic exp_t model(logic [31:0] a, logic [31:0] b, logic [3:0] op,
                                 logic sc, logic sa, logic sf, logic [3:0] fin);
    exp_t e;
    logic [31:0] r;
    logic c, v, arith, cmp;
    longint ua, ub, sa_, sb_, cin, s;
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    sa_ = longint'($signed(a));
    sb_ = longint'($signed(b));
    cin = longint'(fin[1]);
    c = fin[1];
    v = fin[0];
    arith = 1'b1;
    r = '0;
    case (op)
      4'h2, 4'hA: begin r = a - b; c = (ua >= ub); s = sa_ - sb_; v = out_of_range(s); end
      4'h3:       begin r = b - a; c = (ub >= ua); s = sb_ - sa_; v = out_of_range(s); end
      4'h4, 4'hB: begin r = a + b; c = (ua + ub) > 64'hFFFFFFFF; s = sa_ + sb_; v = out_of_range(s); end
      4'h5: begin r = a + b + 32'(fin[1]); c = (ua + ub + cin) > 64'hFFFFFFFF;
                  s = sa_ + sb_ + cin; v = out_of_range(s); end
      4'h6: begin r = a - b - 32'(!fin[1]); c = (ua >= ub + (1 - cin));
                  s = sa_ - sb_ - (1 - cin); v = out_of_range(s); end
      4'h7: begin r = b - a - 32'(!fin[1]); c = (ub >= ua + (1 - cin));
                  s = sb_ - sa_ - (1 - cin); v = out_of_range(s); end
      default: begin
        arith = 1'b0;
        case (op)
          4'h0, 4'h8: r = a & b;
          4'h1, 4'h9: r = a ^ b;
          4'hC:       r = a | b;
          4'hD:       r = b;
          4'hE:       r = a & ~b;
          default:    r = ~b;
        endcase
      end
    endcase
    if (!arith) begin
      c = sa ? sc : fin[1];
      v = fin[0];
    end
    cmp   = (op >= 4'h8) && (op <= 4'hB);
    e.res = r;
    e.wr  = !cmp;
    e.fl  = (sf || cmp) ? {r[31], (r == 0), c, v} : fin;
    e.op  = op;
    return e;
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [3:0] op,
                       logic sc, logic sa, logic sf, logic [3:0] fin);
    @(negedge clk);
    in_valid   = 1'b1;
    opnd_a     = a;
    opnd_b     = b;
    opcode     = op;
    shf_carry  = sc;
    shf_active = sa;
    set_flags  = sf;
    flags_in   = fin;
    sb.push_back(model(a, b, op, sc, sa, sf, fin));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opnd_a   = $urandom;
      opcode   = 4'($urandom);
    end
  endtask

  // Monitor: results are due one rising edge after capture
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2 unexpected beat", 32'(out_valid), 32'd0);
        end else begin
          exp_t e;
          string rq, fq;
          e = sb.pop_front();
          if (e.op >= 4'h8 && e.op <= 4'hB) rq = "R5 result";
          else if (e.op >= 4'h2 && e.op <= 4'h7) rq = "R4 result";
          else rq = "R3 result";
          chk(result == e.res, rq, result, e.res);
          chk(wr_en == e.wr, e.wr ? "R10 wr_en" : "R5 wr_en", 32'(wr_en), 32'(e.wr));
          if ((e.op >= 4'h2 && e.op <= 4'h7) || e.op == 4'hA || e.op == 4'hB)
            fq = "R6/R7/R9 flags";
          else
            fq = "R6/R8/R9 flags";
          chk(flags_out == e.fl, fq, 32'(flags_out), 32'(e.fl));
        end
      end
    end
  end

  initial begin
    logic [31:0] edges [4];
    edges[0] = 32'h0000_0000;
    edges[1] = 32'h7FFF_FFFF;
    edges[2] = 32'h8000_0000;
    edges[3] = 32'hFFFF_FFFF;

    // R1: reset must override a valid beat
    in_valid = 1'b1;
    opnd_a   = 32'h1234_5678;
    opnd_b   = 32'hFFFF_0000;
    opcode   = 4'hD;
    flags_in = 4'hF;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    chk(wr_en == 1'b0, "R1 wr_en", 32'(wr_en), 32'd0);
    chk(result == 32'd0, "R1 result", result, 32'd0);
    chk(flags_out == 4'd0, "R1 flags", 32'(flags_out), 32'd0);
    rst      = 1'b0;
    in_valid = 1'b0;

    // Edge sweep over all codes and both carry values
    for (int op = 0; op < 16; op++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int i = 0; i < 4; i++) begin
          for (int j = 0; j < 4; j++) begin
            drive(edges[i], edges[j], 4'(op), 1'(i ^ j), 1'(j[0]),
                  1'(~i[0] | j[1]), {2'(i), 1'(ci), 1'(j[0])});
          end
        end
        idle(1);
      end
    end

    // R8: shifter carry taken only when a rotation occurred
    drive(32'hF0F0_F0F0, 32'h0F0F_0F0F, 4'h0, 1'b1, 1'b1, 1'b1, 4'b0000);
    drive(32'hF0F0_F0F0, 32'h0F0F_0F0F, 4'h0, 1'b1, 1'b0, 1'b1, 4'b0000);
    drive(32'h0000_0001, 32'h8000_0000, 4'hD, 1'b0, 1'b0, 1'b1, 4'b0011);
    // R9: no update without set_flags
    drive(32'h7FFF_FFFF, 32'h0000_0001, 4'h4, 1'b0, 1'b0, 1'b0, 4'b0110);
    // R5: compare ignores set_flags=0
    drive(32'h0000_0005, 32'h0000_0005, 4'hA, 1'b0, 1'b0, 1'b0, 4'b0000);

    // Random patterns with random gaps
    for (int k = 0; k < 1500; k++) begin
      drive($urandom, $urandom, 4'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 4'($urandom));
      if (($urandom % 7) == 0) idle(1 + ($urandom % 3));
    end

    idle(4);
    chk(sb.size() == 0, "R2 pending beats", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R2 watchdog expired", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule